// File: doc/BRIEF.md
# Alternating Warp Issue Scheduler

This block chooses which resident warp issues next. It runs one scheduler tick on every second clock. The ticks alternate between the main arithmetic lane group (SP slot) and the special-function unit (SFU slot). Each cycle the host presents a ready flag and a 3-bit instruction class for every warp. It also presents a per-warp flag that marks a multiply which directly follows a multiply-add just issued on the SP. On each tick the block either issues one warp or stays idle. For an issue it reports the warp index and the unit the warp goes to.

The SP slot takes general, multiply-add and multiply work. The SFU slot takes transcendental and interpolation work. The SFU slot also takes multiplies that pair with a preceding multiply-add, and these outrank the special-function requests. A small counter stops paired multiplies from holding off special-function work for ever. Within each class, the choice among warps is round-robin per unit. A granted warp stays blocked until the host drops and raises its ready flag again. A warp that was just issued on the SFU slot cannot return on the SP slot that follows.

Top module: `warp_issue_sched`

## Requirements
- R1: A scheduler tick occurs on every second clock. `issue_valid` is never high in two consecutive clocks. The first tick after reset is an SP slot, and its result appears one clock after that tick's edge.
- R2: Ticks alternate strictly between SP slots (`issue_unit`=0) and SFU slots (`issue_unit`=1).
- R3: Each warp w has a class in `warp_class[3w+2:3w]`. The codes are 0 general, 1 multiply-add, 2 multiply, 3 transcendental, 4 interpolation; codes 5 to 7 are never issued. An SP slot issues only classes 0, 1 and 2. An SFU slot issues only classes 3 and 4, plus class 2 when the warp's `mul_paired` bit is set. A multiply without `mul_paired` never goes to the SFU.
- R4: On an SFU slot, a paired multiply wins over transcendental and interpolation requests, unless R5 applies.
- R5: Suppose the last 4 SFU grants all went to paired multiplies while special-function requests were pending. Then the next SFU slot that has a special-function request pending grants that request. The count restarts when a special-function request is granted, and when a paired multiply is granted with no special-function request pending.
- R6: Within one class, a slot grants the first requesting warp after the last warp granted on that unit, wrapping around. The pointer is shared by all classes of that unit. After reset both searches start at warp 0.
- R7: A warp granted on an SFU slot is not granted on the SP slot that immediately follows. A warp granted a multiply-add on an SP slot may get its paired multiply on the very next SFU slot.
- R8: A paired multiply that loses its SFU slot stays eligible and is issued on a following SP slot.
- R9: Once granted, a warp is not eligible again until its `warp_ready` has been seen low for at least one clock.
- R10: When no warp is eligible for a slot, `issue_valid` stays low for that tick.
- R11: `rst_n` is an asynchronous active-low reset, and `issue_valid` is low while it is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warp_ready | input | NUM_WARPS | Per-warp ready flag |
| warp_class | input | 3*NUM_WARPS | Per-warp next-instruction class, 3 bits per warp |
| mul_paired | input | NUM_WARPS | Per-warp flag: multiply follows a multiply-add just issued on the SP |
| issue_valid | output | 1 | One-clock strobe: a warp is issued |
| issue_warp | output | clog2(NUM_WARPS) | Index of the issued warp |
| issue_unit | output | 1 | Target unit: 0 SP, 1 SFU |

## Verification
The assertions assume two things about the host. It holds `warp_class` and `mul_paired` steady around each tick edge. It also raises `mul_paired` only on warps whose class is multiply. The class-legality and alternation properties compare the issued warp with the inputs it was chosen from, so they rely on both. The stimulus drives all inputs on the falling edge. It sets the paired flag only on multiply warps and changes inputs only between ticks. Each tick's ready set is dropped before the next tick unless a test deliberately holds it to exercise the lock.

// File: rtl/wis_pkg.sv
package wis_pkg;

    localparam int CLS_W = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_GEN    = 3'd0,
        CLS_MAD    = 3'd1,
        CLS_MUL    = 3'd2,
        CLS_TRANS  = 3'd3,
        CLS_INTERP = 3'd4
    } wis_cls_e;

    localparam logic UNIT_SP  = 1'b0;
    localparam logic UNIT_SFU = 1'b1;

endpackage

// File: rtl/wis_class_sort.sv
module wis_class_sort
    import wis_pkg::*;
#(
    parameter int NUM_WARPS = 32
) (
    input  logic [NUM_WARPS-1:0]       avail,
    input  logic [CLS_W*NUM_WARPS-1:0] warp_class,
    input  logic [NUM_WARPS-1:0]       mul_paired,
    output logic [NUM_WARPS-1:0]       sp_req,
    output logic [NUM_WARPS-1:0]       pair_req,
    output logic [NUM_WARPS-1:0]       spec_req
);

    for (genvar g = 0; g < NUM_WARPS; g++) begin : g_warp
        logic [CLS_W-1:0] cls;
        assign cls         = warp_class[g*CLS_W +: CLS_W];
        assign sp_req[g]   = avail[g] && (cls == CLS_GEN || cls == CLS_MAD || cls == CLS_MUL);
        assign pair_req[g] = avail[g] && (cls == CLS_MUL) && mul_paired[g];
        assign spec_req[g] = avail[g] && (cls == CLS_TRANS || cls == CLS_INTERP);
    end

endmodule

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
    parameter int NUM_WARPS = 32,
    localparam int WID = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic [NUM_WARPS-1:0] req,
    input  logic [WID-1:0]       last,
    output logic                 found,
    output logic [WID-1:0]       idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 1; k <= NUM_WARPS; k++) begin
            if (!found && req[(int'(last) + k) % NUM_WARPS]) begin
                found = 1'b1;
                idx   = WID'((int'(last) + k) % NUM_WARPS);
            end
        end
    end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import wis_pkg::*;
#(
    parameter int NUM_WARPS   = 32,
    parameter int STARVE_LIM  = 4,
    localparam int WID = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int SW  = $clog2(STARVE_LIM + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_WARPS-1:0]       warp_ready,
    input  logic [CLS_W*NUM_WARPS-1:0] warp_class,
    input  logic [NUM_WARPS-1:0]       mul_paired,
    output logic                       issue_valid,
    output logic [WID-1:0]             issue_warp,
    output logic                       issue_unit
);

    localparam logic [NUM_WARPS-1:0] ONE_HOT0 = NUM_WARPS'(1);

    typedef struct packed {
        logic [1:0]           ph;
        logic [WID-1:0]       rr_sp;
        logic [WID-1:0]       rr_sfu;
        logic [NUM_WARPS-1:0] lock;
        logic [NUM_WARPS-1:0] excl;
        logic [SW-1:0]        starve;
        logic                 out_v;
        logic [WID-1:0]       out_w;
        logic                 out_u;
    } sched_st_t;

    sched_st_t st_q, st_d;

    logic                 tick_sp, tick_sfu;
    logic [NUM_WARPS-1:0] avail;
    logic [NUM_WARPS-1:0] sp_raw, pair_req, spec_req, sp_req;
    logic                 sp_v, pair_v, spec_v;
    logic [WID-1:0]       sp_id, pair_id, spec_id;
    logic                 force_spec;
    logic                 sfu_v;
    logic [WID-1:0]       sfu_id;
    logic                 sfu_is_pair;

    assign tick_sp  = (st_q.ph == 2'd0);
    assign tick_sfu = (st_q.ph == 2'd2);
    assign avail    = warp_ready & ~st_q.lock;
    assign sp_req   = sp_raw & ~st_q.excl;

    wis_class_sort #(.NUM_WARPS(NUM_WARPS)) sort_i (
        .avail      (avail),
        .warp_class (warp_class),
        .mul_paired (mul_paired),
        .sp_req     (sp_raw),
        .pair_req   (pair_req),
        .spec_req   (spec_req)
    );

    wis_rr_pick #(.NUM_WARPS(NUM_WARPS)) pick_sp_i (
        .req (sp_req), .last (st_q.rr_sp), .found (sp_v), .idx (sp_id)
    );

    wis_rr_pick #(.NUM_WARPS(NUM_WARPS)) pick_pair_i (
        .req (pair_req), .last (st_q.rr_sfu), .found (pair_v), .idx (pair_id)
    );

    wis_rr_pick #(.NUM_WARPS(NUM_WARPS)) pick_spec_i (
        .req (spec_req), .last (st_q.rr_sfu), .found (spec_v), .idx (spec_id)
    );

    always_comb begin
        force_spec  = spec_v && (st_q.starve >= SW'(STARVE_LIM));
        sfu_is_pair = pair_v && !force_spec;
        sfu_v       = sfu_is_pair || spec_v;
        sfu_id      = sfu_is_pair ? pair_id : spec_id;
    end

    always_comb begin
        st_d       = st_q;
        st_d.ph    = st_q.ph + 2'd1;
        st_d.out_v = 1'b0;
        st_d.lock  = st_q.lock & warp_ready;

        if (tick_sp) begin
            st_d.excl = '0;
            if (sp_v) begin
                st_d.out_v = 1'b1;
                st_d.out_w = sp_id;
                st_d.out_u = UNIT_SP;
                st_d.rr_sp = sp_id;
                st_d.lock  = st_d.lock | (ONE_HOT0 << sp_id);
            end
        end

        if (tick_sfu) begin
            st_d.excl = '0;
            if (sfu_v) begin
                st_d.out_v  = 1'b1;
                st_d.out_w  = sfu_id;
                st_d.out_u  = UNIT_SFU;
                st_d.rr_sfu = sfu_id;
                st_d.lock   = st_d.lock | (ONE_HOT0 << sfu_id);
                st_d.excl   = ONE_HOT0 << sfu_id;
                if (sfu_is_pair) begin
                    st_d.starve = spec_v ? st_q.starve + SW'(1) : '0;
                end else begin
                    st_d.starve = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.rr_sp  <= WID'(NUM_WARPS - 1);
            st_q.rr_sfu <= WID'(NUM_WARPS - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign issue_valid = st_q.out_v;
    assign issue_warp  = st_q.out_w;
    assign issue_unit  = st_q.out_u;

    // R1: a strobe is always followed by an idle clock
    a_r1_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> !issue_valid);

    // R2: issues on neighbouring ticks target different units
    a_r2_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid ##2 issue_valid) |-> (issue_unit != $past(issue_unit, 2)));

    // R3: the SFU slot only takes special work or a paired multiply
    a_r3_sfu_class: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_sfu && sfu_v) |->
            (warp_class[sfu_id*CLS_W +: CLS_W] == CLS_TRANS ||
             warp_class[sfu_id*CLS_W +: CLS_W] == CLS_INTERP ||
             (warp_class[sfu_id*CLS_W +: CLS_W] == CLS_MUL && mul_paired[sfu_id])));

    // R3: the SP slot only takes general, multiply-add or multiply
    a_r3_sp_class: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_sp && sp_v) |->
            (warp_class[sp_id*CLS_W +: CLS_W] == CLS_GEN ||
             warp_class[sp_id*CLS_W +: CLS_W] == CLS_MAD ||
             warp_class[sp_id*CLS_W +: CLS_W] == CLS_MUL));

    // R7: an SFU grant never comes straight back on the next SP slot
    a_r7_sfu_then_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_unit == UNIT_SFU ##2 issue_valid) |->
            (issue_warp != $past(issue_warp, 2)));

    // R10: no requester means no strobe
    a_r10_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        ((tick_sp && sp_req == '0) || (tick_sfu && pair_req == '0 && spec_req == '0))
            |=> !issue_valid);

endmodule

// File: tb/warp_issue_sched_tb_top.sv
module warp_issue_sched_tb_top;

    localparam int NW = 8;

    localparam logic [2:0] CG = 3'd0;
    localparam logic [2:0] CA = 3'd1;
    localparam logic [2:0] CM = 3'd2;
    localparam logic [2:0] CT = 3'd3;
    localparam logic [2:0] CI = 3'd4;

    typedef struct packed {
        logic        unit;
        logic [7:0]  rdy;
        logic [23:0] cls;
        logic [7:0]  pr;
        logic        ev;
        logic [2:0]  ew;
    } vec_t;

    localparam int NV = 20;
    // classes listed warp7 .. warp0
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'b0000_0110, {CG,CG,CG,CG,CG,CG,CG,CG}, 8'h00, 1'b1, 3'd1}, // R6 first pick
        '{1'b1, 8'b0010_1000, {CG,CG,CM,CG,CT,CG,CG,CG}, 8'h20, 1'b1, 3'd5}, // R4
        '{1'b0, 8'b0010_0101, {CG,CG,CG,CG,CG,CG,CG,CG}, 8'h00, 1'b1, 3'd2}, // R6
        '{1'b1, 8'b0101_0000, {CG,CI,CG,CM,CG,CG,CG,CG}, 8'h00, 1'b1, 3'd6}, // R3 unpaired mul
        '{1'b0, 8'b1001_0000, {CT,CG,CG,CM,CG,CG,CG,CG}, 8'h00, 1'b1, 3'd4}, // R3
        '{1'b1, 8'b0000_1110, {CG,CG,CG,CG,CA,CG,CM,CG}, 8'h00, 1'b0, 3'd0}, // R10
        '{1'b0, 8'b0001_1000, {CG,CG,CG,CI,CT,CG,CG,CG}, 8'h00, 1'b0, 3'd0}, // R10
        '{1'b1, 8'b1000_0011, {CM,CG,CG,CG,CG,CG,CT,CM}, 8'h81, 1'b1, 3'd7}, // R6 R4
        '{1'b0, 8'b1000_0001, {CG,CG,CG,CG,CG,CG,CG,CA}, 8'h00, 1'b1, 3'd0}, // R7
        '{1'b1, 8'b0000_0110, {CG,CG,CG,CG,CG,CT,CM,CG}, 8'h02, 1'b1, 3'd1}, // R5 count 2
        '{1'b0, 8'b0000_1000, {CG,CG,CG,CG,CG,CG,CG,CG}, 8'h00, 1'b1, 3'd3},
        '{1'b1, 8'b0010_0100, {CG,CG,CI,CG,CG,CM,CG,CG}, 8'h04, 1'b1, 3'd2}, // R5 count 3
        '{1'b0, 8'b0000_0000, {CG,CG,CG,CG,CG,CG,CG,CG}, 8'h00, 1'b0, 3'd0},
        '{1'b1, 8'b0010_1000, {CG,CG,CI,CG,CM,CG,CG,CG}, 8'h08, 1'b1, 3'd3}, // R5 count 4
        '{1'b0, 8'b0010_0000, {CG,CG,CA,CG,CG,CG,CG,CG}, 8'h00, 1'b1, 3'd5},
        '{1'b1, 8'b0011_0000, {CG,CG,CI,CM,CG,CG,CG,CG}, 8'h10, 1'b1, 3'd5}, // R5 forced
        '{1'b0, 8'b0011_0000, {CG,CG,CG,CM,CG,CG,CG,CG}, 8'h10, 1'b1, 3'd4}, // R8 fallback
        '{1'b1, 8'b0101_0000, {CG,CT,CG,CM,CG,CG,CG,CG}, 8'h10, 1'b1, 3'd4}, // R5 restarted
        '{1'b0, 8'b0000_0000, {CG,CG,CG,CG,CG,CG,CG,CG}, 8'h00, 1'b0, 3'd0},
        '{1'b1, 8'b0000_0001, {CG,CG,CG,CG,CG,CG,CG,CM}, 8'h01, 1'b1, 3'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NW-1:0] warp_ready = '0;
    logic [3*NW-1:0] warp_class = '0;
    logic [NW-1:0] mul_paired = '0;
    logic          issue_valid;
    logic [2:0]    issue_warp;
    logic          issue_unit;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    warp_issue_sched #(.NUM_WARPS(NW), .STARVE_LIM(4)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .warp_ready  (warp_ready),
        .warp_class  (warp_class),
        .mul_paired  (mul_paired),
        .issue_valid (issue_valid),
        .issue_warp  (issue_warp),
        .issue_unit  (issue_unit)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_tick(input logic [7:0] rdy, input logic [23:0] cls,
                            input logic [7:0] pr, input logic ev, input logic [2:0] ew,
                            input logic eu, input bit keep, input string req);
        @(negedge clk);
        chk(issue_valid == 1'b0, "R1", "idle clock strobe", int'(issue_valid), 0);
        warp_ready = rdy;
        warp_class = cls;
        mul_paired = pr;
        @(negedge clk);
        chk(issue_valid == ev, req, "issue_valid", int'(issue_valid), int'(ev));
        if (ev && issue_valid) begin
            chk(issue_warp == ew, req, "issue_warp", int'(issue_warp), int'(ew));
            chk(issue_unit == eu, "R2", "issue_unit", int'(issue_unit), int'(eu));
        end
        if (!keep) warp_ready = '0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R11: reset holds the strobe low
        repeat (3) @(negedge clk);
        warp_ready = 8'hFF;
        @(negedge clk);
        chk(issue_valid == 1'b0, "R11", "valid in reset", int'(issue_valid), 0);
        warp_ready = '0;
        @(posedge clk);
        #2 rst_n = 1'b1;

        // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R10
        for (int i = 0; i < NV; i++) begin
            run_tick(VEC[i].rdy, VEC[i].cls, VEC[i].pr, VEC[i].ev, VEC[i].ew,
                     VEC[i].unit, 1'b0, "R6/table");
        end

        // R9: lock holds while ready stays high
        run_tick(8'h02, {8{CG}}, 8'h00, 1'b1, 3'd1, 1'b0, 1'b1, "R9");
        run_tick(8'h02, {8{CG}}, 8'h00, 1'b0, 3'd0, 1'b1, 1'b1, "R9");
        run_tick(8'h02, {8{CG}}, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, "R9");
        run_tick(8'h00, {8{CG}}, 8'h00, 1'b0, 3'd0, 1'b1, 1'b0, "R10");
        run_tick(8'h02, {8{CG}}, 8'h00, 1'b1, 3'd1, 1'b0, 1'b0, "R9");
        run_tick(8'h00, {8{CG}}, 8'h00, 1'b0, 3'd0, 1'b1, 1'b0, "R10");

        // R7: multiply-add on SP, its paired multiply on the next SFU slot
        run_tick(8'h04, {CG,CG,CG,CG,CG,CA,CG,CG}, 8'h00, 1'b1, 3'd2, 1'b0, 1'b0, "R7");
        run_tick(8'h04, {CG,CG,CG,CG,CG,CM,CG,CG}, 8'h04, 1'b1, 3'd2, 1'b1, 1'b0, "R7");
        // R7: same warp cannot return on the following SP slot
        run_tick(8'h04, {8{CG}}, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, "R7");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule